// File: doc/BRIEF.md
# Delayed Synaptic Input Ring Buffer

This block gathers incoming synaptic events into small circular buffers. Each neuron has one buffer for excitatory input and one for inhibitory input. A buffer has 16 slots, and each slot stands for one future timestep. A single time pointer, shared by all buffers, marks the slot that belongs to the next timestep.

On the write port, a 32-bit static synaptic word is decoded into four fields: the target neuron, the receptor, the delay and the weight. The weight is added, with saturation, into slot `(pointer + delay) mod 16` of the selected buffer. On the consume port, the neuron update names a neuron. The block returns both receptor slots at the pointer, each widened to a 32-bit fixed-point value by a programmable left shift, and clears those two slots. A step input moves the pointer on by one slot at each timestep.

After reset, a two-state controller sweeps the storage clear, one neuron per cycle (state `ST_SWEEP`). It then moves to `ST_RUN` on the transition `sweep_done`, which fires when the last neuron row has been cleared. `ST_RUN` has no exit; only reset returns the controller to `ST_SWEEP`.

Top module: `syn_delay_ring`

## Requirements
- R1: A write word is decoded as follows: weight in bits [31:16], spare bits [15:13] (ignored), delay in [12:9], receptor in [8] (0 = excitatory, 1 = inhibitory), and neuron ID in [7:0]. The weight is added into slot (pointer + delay) mod 16 of that neuron's buffer for that receptor.
- R2: Several weights aimed at the same neuron, receptor and slot are summed.
- R3: An accumulation that would exceed 0xFFFF stores 0xFFFF. It also raises `sat_o` for exactly the one cycle after the write's clock edge.
- R4: A consume request returns the excitatory and inhibitory slots at the pointer one cycle later, with `rd_done_o` high. It clears both slots, so an immediate second consume returns zero. `rd_done_o` is low in any cycle not preceded by an accepted consume.
- R5: Each `step_i` pulse moves the pointer forward by one slot, wrapping from slot 15 to slot 0. A delay that passes slot 15 therefore lands in a lower-numbered slot.
- R6: Each returned value is the 16-bit slot, zero-extended to 32 bits and shifted left by the `shift_i` value sampled with the request. For example, a shift of 6 puts the slot's LSB at bit 6, which is worth 2^-9 in a format with 15 fraction bits.
- R7: When a write targets the slot being consumed in the same cycle, the consume returns the old contents. The slot is then left holding only the new weight.
- R8: Right after reset, `ready_o`, `rd_done_o` and `sat_o` are low. While `ready_o` is low (about NUM_NEURONS cycles), writes and consumes are ignored. Once `ready_o` rises, it stays high.
- R9: A write whose neuron ID is NUM_NEURONS or higher changes no buffer. A consume of such an ID still completes, but returns zero.
- R10: The word 0x024D150C adds 589 to the inhibitory buffer of neuron 12, ten timesteps ahead of the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Advance the time pointer by one slot |
| wr_valid_i | input | 1 | Synaptic word present |
| wr_word_i | input | 32 | Static synaptic word |
| rd_valid_i | input | 1 | Consume request |
| rd_neuron_i | input | 8 | Neuron to consume |
| shift_i | input | SHIFT_W | Left shift for the fixed-point conversion |
| ready_o | output | 1 | Storage cleared, requests accepted |
| rd_done_o | output | 1 | Consume result valid |
| rd_exc_o | output | 32 | Converted excitatory slot |
| rd_inh_o | output | 32 | Converted inhibitory slot |
| sat_o | output | 1 | Previous write saturated |

## Verification
Every result is registered once. The consume data and `rd_done_o` appear on the clock edge after the request cycle, and the slot is cleared at that same edge. `sat_o` follows the saturating write by one edge. A write becomes visible to a consume issued in any later cycle, once the pointer has reached the target slot. The bench drives inputs on falling edges and samples results on the following falling edge, so exactly one rising edge separates a stimulus from its check. The sweep's length is measured by polling `ready_o`, within a bound.

// File: rtl/syn_delay_pkg.sv
package syn_delay_pkg;

    localparam int DLY_W  = 4;
    localparam int VAL_W  = 16;
    localparam int OUT_W  = 32;
    localparam int RCPTS  = 2;

    typedef struct packed {
        logic [VAL_W-1:0] weight;
        logic [2:0]       spare;
        logic [DLY_W-1:0] delay;
        logic             rtype;
        logic [7:0]       nid;
    } syn_word_t;

    typedef enum logic [0:0] {
        ST_SWEEP = 1'b0,
        ST_RUN   = 1'b1
    } ring_state_t;

    function automatic logic [OUT_W-1:0] to_fixed(input logic [VAL_W-1:0] raw,
                                                  input logic [4:0] sh);
        logic [OUT_W-1:0] wide;
        wide = {{(OUT_W-VAL_W){1'b0}}, raw};
        return wide << sh;
    endfunction

endpackage

// File: rtl/syn_word_dec.sv
module syn_word_dec
    import syn_delay_pkg::*;
#(
    parameter int NUM_NEURONS = 16,
    localparam int NID_W = $clog2(NUM_NEURONS)
) (
    input  logic [31:0]      word_i,
    input  logic [DLY_W-1:0] ptr_i,
    output logic [NID_W-1:0] nid_o,
    output logic [DLY_W-1:0] slot_o,
    output logic             rtype_o,
    output logic [VAL_W-1:0] weight_o,
    output logic             id_ok_o
);
    syn_word_t w;

    always_comb begin
        w        = syn_word_t'(word_i);
        nid_o    = w.nid[NID_W-1:0];
        slot_o   = ptr_i + w.delay;
        rtype_o  = w.rtype;
        weight_o = w.weight;
        id_ok_o  = ({1'b0, w.nid} < 9'(NUM_NEURONS));
    end
endmodule

// File: rtl/syn_rcpt_bank.sv
module syn_rcpt_bank #(
    parameter int NEURONS = 16,
    parameter int SLOTS   = 16,
    parameter int VAL_W   = 16,
    localparam int NID_W  = $clog2(NEURONS),
    localparam int SLOT_AW = $clog2(SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_en,
    input  logic [NID_W-1:0]   clr_idx,
    input  logic               wr_en,
    input  logic [NID_W-1:0]   wr_n,
    input  logic [SLOT_AW-1:0] wr_s,
    input  logic [VAL_W-1:0]   wr_w,
    input  logic               rd_en,
    input  logic [NID_W-1:0]   rd_n,
    input  logic [SLOT_AW-1:0] rd_s,
    output logic [VAL_W-1:0]   rd_raw,
    output logic               sat
);
    logic [VAL_W-1:0] mem [NEURONS][SLOTS];
    logic             same_slot;
    logic [VAL_W-1:0] base;
    logic [VAL_W:0]   sum;
    logic [VAL_W-1:0] next_val;

    always_comb begin
        same_slot = rd_en && (rd_n == wr_n) && (rd_s == wr_s);
        base      = same_slot ? '0 : mem[wr_n][wr_s];
        sum       = {1'b0, base} + {1'b0, wr_w};
        next_val  = sum[VAL_W] ? '1 : sum[VAL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (clr_en) begin
            for (int s = 0; s < SLOTS; s++) begin
                mem[clr_idx][s] <= '0;
            end
        end else begin
            if (rd_en) begin
                mem[rd_n][rd_s] <= '0;
            end
            if (wr_en) begin
                mem[wr_n][wr_s] <= next_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_raw <= '0;
            sat    <= 1'b0;
        end else begin
            rd_raw <= rd_en ? mem[rd_n][rd_s] : '0;
            sat    <= wr_en && sum[VAL_W];
        end
    end
endmodule

// File: rtl/syn_delay_ring.sv
module syn_delay_ring
    import syn_delay_pkg::*;
#(
    parameter int NUM_NEURONS = 16,
    parameter int SHIFT_W     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_i,
    input  logic               wr_valid_i,
    input  logic [31:0]        wr_word_i,
    input  logic               rd_valid_i,
    input  logic [7:0]         rd_neuron_i,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic               ready_o,
    output logic               rd_done_o,
    output logic [OUT_W-1:0]   rd_exc_o,
    output logic [OUT_W-1:0]   rd_inh_o,
    output logic               sat_o
);
    localparam int NID_W = $clog2(NUM_NEURONS);
    localparam int SLOTS = 1 << DLY_W;

    ring_state_t        state_q, state_d;
    logic [NID_W-1:0]   sweep_q;
    logic [DLY_W-1:0]   ptr_q;
    logic [SHIFT_W-1:0] shift_q;
    logic               rd_done_q;
    logic               run_en, clr_en;

    logic [NID_W-1:0]   dec_nid;
    logic [DLY_W-1:0]   dec_slot;
    logic               dec_type;
    logic [VAL_W-1:0]   dec_weight;
    logic               dec_ok;

    logic               wr_ok, rd_acc, rd_ok;
    logic [VAL_W-1:0]   raw   [RCPTS];
    logic [RCPTS-1:0]   sat_v;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SWEEP: if (sweep_q == NID_W'(NUM_NEURONS - 1)) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_SWEEP;
            sweep_q   <= '0;
            ptr_q     <= '0;
            shift_q   <= '0;
            rd_done_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            rd_done_q <= rd_acc;
            if (clr_en) sweep_q <= sweep_q + 1'b1;
            if (run_en && step_i) ptr_q <= ptr_q + 1'b1;
            if (rd_acc) shift_q <= shift_i;
        end
    end

    always_comb begin
        run_en = 1'b0;
        clr_en = 1'b0;
        unique case (state_q)
            ST_SWEEP: clr_en = 1'b1;
            ST_RUN:   run_en = 1'b1;
        endcase
    end

    syn_word_dec #(.NUM_NEURONS(NUM_NEURONS)) dec_i (
        .word_i   (wr_word_i),
        .ptr_i    (ptr_q),
        .nid_o    (dec_nid),
        .slot_o   (dec_slot),
        .rtype_o  (dec_type),
        .weight_o (dec_weight),
        .id_ok_o  (dec_ok)
    );

    always_comb begin
        wr_ok  = run_en && wr_valid_i && dec_ok;
        rd_acc = run_en && rd_valid_i;
        rd_ok  = rd_acc && ({1'b0, rd_neuron_i} < 9'(NUM_NEURONS));
    end

    for (genvar g = 0; g < RCPTS; g++) begin : g_bank
        syn_rcpt_bank #(
            .NEURONS (NUM_NEURONS),
            .SLOTS   (SLOTS),
            .VAL_W   (VAL_W)
        ) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_en  (clr_en),
            .clr_idx (sweep_q),
            .wr_en   (wr_ok && (dec_type == 1'(g))),
            .wr_n    (dec_nid),
            .wr_s    (dec_slot),
            .wr_w    (dec_weight),
            .rd_en   (rd_ok),
            .rd_n    (rd_neuron_i[NID_W-1:0]),
            .rd_s    (ptr_q),
            .rd_raw  (raw[g]),
            .sat     (sat_v[g])
        );
    end

    always_comb begin
        ready_o   = run_en;
        rd_done_o = rd_done_q;
        rd_exc_o  = to_fixed(raw[0], 5'(shift_q));
        rd_inh_o  = to_fixed(raw[1], 5'(shift_q));
        sat_o     = |sat_v;
    end
endmodule

// File: rtl/syn_delay_ring_chk.sv
module syn_delay_ring_chk #(
    parameter int SHIFT_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_valid_i,
    input logic               rd_valid_i,
    input logic [SHIFT_W-1:0] shift_i,
    input logic               ready_o,
    input logic               rd_done_o,
    input logic [31:0]        rd_exc_o,
    input logic [31:0]        rd_inh_o,
    input logic               sat_o
);
    assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o);

    assert_quiet_sweep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> (!rd_done_o && !sat_o));

    assert_done_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_i && ready_o) |=> rd_done_o);

    assert_no_stray_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid_i && ready_o) |=> !rd_done_o);

    assert_sat_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sat_o |-> $past(wr_valid_i && ready_o));

    assert_shift_low_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done_o |-> (((rd_exc_o | rd_inh_o) & ((32'd1 << $past(shift_i)) - 32'd1)) == 32'd0));
endmodule

bind syn_delay_ring syn_delay_ring_chk #(.SHIFT_W(SHIFT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid_i (wr_valid_i),
    .rd_valid_i (rd_valid_i),
    .shift_i    (shift_i),
    .ready_o    (ready_o),
    .rd_done_o  (rd_done_o),
    .rd_exc_o   (rd_exc_o),
    .rd_inh_o   (rd_inh_o),
    .sat_o      (sat_o)
);

// File: tb/syn_delay_ring_tb_top.sv
`timescale 1ns/1ps
module syn_delay_ring_tb_top;
    localparam int NN = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic        wr_valid_i = 1'b0;
    logic [31:0] wr_word_i = '0;
    logic        rd_valid_i = 1'b0;
    logic [7:0]  rd_neuron_i = '0;
    logic [3:0]  shift_i = '0;
    logic        ready_o, rd_done_o, sat_o;
    logic [31:0] rd_exc_o, rd_inh_o;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    syn_delay_ring #(.NUM_NEURONS(NN), .SHIFT_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .step_i(step_i),
        .wr_valid_i(wr_valid_i), .wr_word_i(wr_word_i),
        .rd_valid_i(rd_valid_i), .rd_neuron_i(rd_neuron_i), .shift_i(shift_i),
        .ready_o(ready_o), .rd_done_o(rd_done_o),
        .rd_exc_o(rd_exc_o), .rd_inh_o(rd_inh_o), .sat_o(sat_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mkword(input int w, input int dly, input int typ, input int nid);
        return (32'(w) << 16) | (32'(dly) << 9) | (32'(typ) << 8) | 32'(nid);
    endfunction

    task automatic do_write(input logic [31:0] word, output logic sat);
        @(negedge clk);
        wr_valid_i = 1'b1;
        wr_word_i  = word;
        @(negedge clk);
        sat = sat_o;
        wr_valid_i = 1'b0;
    endtask

    task automatic do_step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            step_i = 1'b1;
            @(negedge clk);
            step_i = 1'b0;
        end
    endtask

    task automatic consume(input int nid, input int sh, output logic done,
                           output logic [31:0] exc, output logic [31:0] inh);
        @(negedge clk);
        rd_valid_i  = 1'b1;
        rd_neuron_i = 8'(nid);
        shift_i     = 4'(sh);
        @(negedge clk);
        done = rd_done_o;
        exc  = rd_exc_o;
        inh  = rd_inh_o;
        rd_valid_i = 1'b0;
    endtask

    task automatic t_reset_sweep();
        logic s, d;
        logic [31:0] e, i;
        int waited;
        check("R8 ready low after reset", 32'(ready_o), 32'd0);
        check("R8 done low after reset", 32'(rd_done_o), 32'd0);
        check("R8 sat low after reset", 32'(sat_o), 32'd0);
        do_write(mkword(77, 0, 0, 2), s);
        @(negedge clk);
        rd_valid_i = 1'b1;
        rd_neuron_i = 8'd2;
        @(negedge clk);
        rd_valid_i = 1'b0;
        check("R8 consume ignored in sweep", 32'(rd_done_o), 32'd0);
        waited = 0;
        while (!ready_o && waited < NN + 4) begin
            @(negedge clk);
            waited++;
        end
        check("R8 ready rises", 32'(ready_o), 32'd1);
        consume(2, 0, d, e, i);
        check("R8 write during sweep dropped", e, 32'd0);
    endtask

    task automatic t_example_R10();
        logic s, d;
        logic [31:0] e, i;
        do_write(32'h024D150C, s);
        consume(12, 6, d, e, i);
        check("R10 not due yet", i, 32'd0);
        do_step(10);
        consume(12, 6, d, e, i);
        check("R10 done", 32'(d), 32'd1);
        check("R10 inh 589<<6", i, 32'd589 << 6);
        check("R10 exc empty", e, 32'd0);
    endtask

    task automatic t_fields_R1();
        logic s, d;
        logic [31:0] e, i;
        do_write(mkword(16'h0123, 3, 0, 7) | 32'h0000_E000, s);
        do_step(3);
        consume(7, 0, d, e, i);
        check("R1 exc with spare bits set", e, 32'h0123);
        check("R1 inh untouched", i, 32'd0);
    endtask

    task automatic t_sum_R2();
        logic s, d;
        logic [31:0] e, i;
        do_write(mkword(1000, 2, 1, 8), s);
        do_write(mkword(234, 2, 1, 8), s);
        do_step(2);
        consume(8, 0, d, e, i);
        check("R2 linear sum", i, 32'd1234);
    endtask

    task automatic t_sat_R3_R6_R4();
        logic s, d;
        logic [31:0] e, i;
        do_write(mkword(16'hFFF0, 0, 0, 5), s);
        check("R3 no sat first", 32'(s), 32'd0);
        do_write(mkword(16'hFFF0, 0, 0, 5), s);
        check("R3 sat pulse", 32'(s), 32'd1);
        @(negedge clk);
        check("R3 sat one cycle", 32'(sat_o), 32'd0);
        consume(5, 15, d, e, i);
        check("R3 R6 clamp shifted by 15", e, 32'h7FFF_8000);
        consume(5, 0, d, e, i);
        check("R4 cleared after consume", e, 32'd0);
        check("R4 done on repeat", 32'(d), 32'd1);
        @(negedge clk);
        check("R4 no stray done", 32'(rd_done_o), 32'd0);
    endtask

    task automatic t_wrap_R5();
        logic s, d;
        logic [31:0] e, i;
        do_write(mkword(7, 15, 0, 3), s);
        do_step(14);
        consume(3, 0, d, e, i);
        check("R5 early slot empty", e, 32'd0);
        do_step(1);
        consume(3, 0, d, e, i);
        check("R5 wrapped delay", e, 32'd7);
    endtask

    task automatic t_collide_R7();
        logic s, d;
        logic [31:0] e, i;
        do_write(mkword(100, 0, 0, 6), s);
        @(negedge clk);
        rd_valid_i  = 1'b1;
        rd_neuron_i = 8'd6;
        shift_i     = 4'd0;
        wr_valid_i  = 1'b1;
        wr_word_i   = mkword(33, 0, 0, 6);
        @(negedge clk);
        check("R7 read sees old", rd_exc_o, 32'd100);
        rd_valid_i = 1'b0;
        wr_valid_i = 1'b0;
        consume(6, 0, d, e, i);
        check("R7 write after clear", e, 32'd33);
    endtask

    task automatic t_range_R9();
        logic s, d;
        logic [31:0] e, i;
        do_write(mkword(50, 0, 0, 20), s);
        consume(4, 0, d, e, i);
        check("R9 alias untouched", e, 32'd0);
        consume(200, 0, d, e, i);
        check("R9 done for bad id", 32'(d), 32'd1);
        check("R9 zero for bad id", e | i, 32'd0);
    endtask

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_sweep();
        t_example_R10();
        t_fields_R1();
        t_sum_R2();
        t_sat_R3_R6_R4();
        t_wrap_R5();
        t_collide_R7();
        t_range_R9();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule